// File: doc/BRIEF.md
# Video Clock and Sync Control Unit

This unit sits beside a display pipeline and handles three small timing jobs driven by the pixel clock. It produces a programmable clock at the pixel rate divided by 4, 8, 16 or 32, with a 50% duty cycle. It passes an externally supplied shift clock through a gate, so that the shift clock is held off for the whole blanking interval. It distributes the composite sync onto the red, green and blue channels, and each channel has its own enable.

One 8-bit control register is written through a single-cycle write strobe and can be read back at all times. The register holds the divider select, the three per-channel sync enables, and a sticky flag. The flag records a sync pulse that arrived outside blanking. Only digital flags are produced here: one registered blank indication and one registered sync indication per channel.

Top module: `vid_clk_sync_ctrl`

## Requirements
- R1: While reset is asserted, prg_clk_o, sck_o, blank_o and sync_rgb_o are all low, and reg_rdata_o reads 0x00.
- R2: The divider select is control bits [1:0], encoded 00 = /4, 01 = /8, 10 = /16, 11 = /32. prg_clk_o is high for N/2 pixel clocks and low for N/2 pixel clocks.
- R3: A new divider select takes effect at the next falling edge of prg_clk_o. A high phase already under way keeps its old length, and the low phase that follows it uses the new N.
- R4: While blank_i stays low, sck_o follows sck_i.
- R5: The shift-clock gate samples blank_i on the falling edge of sck_i. A high pulse on sck_o is never cut short, and sck_o stays low for every sck_i period that starts while the gate is closed.
- R6: Bit 3 enables sync on green. sync_rgb_o[1] goes high one pixel clock after a cycle in which sync_i, blank_i and bit 3 are all high, and stays low otherwise.
- R7: Bit 2 enables sync on red and drives sync_rgb_o[0]. Bit 4 enables sync on blue and drives sync_rgb_o[2]. Each works independently of the other enables, with the same one-cycle timing as green.
- R8: Sync is honoured only while blank_i is high. If sync_i is high while blank_i is low, no channel shows sync, and the sticky error flag (read bit 7) is set on the next clock.
- R9: The error flag stays set until a write with bit 7 set. Such a write clears the flag unless a new error occurs in the same cycle. Bits [4:0] read back the last value written.
- R10: blank_o equals blank_i delayed by one pixel clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register and error flag readback |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Shift clock gated by blanking |
| blank_i | input | 1 | Composite blank, high during blanking |
| sync_i | input | 1 | Composite sync |
| prg_clk_o | output | 1 | Divided pixel clock |
| blank_o | output | 1 | Registered blank indication |
| sync_rgb_o | output | 3 | Per-channel sync flags: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench drives inputs on the falling pixel-clock edge and samples on the next falling edge. A register write, a sync or blank flag, and the error flag are therefore each checked exactly one rising edge after their stimulus. The divided clock is measured by counting pixel clocks between its transitions. For a select change, the bench counts the high phase during which the write landed and the low phase after it, and expects the old and new half-periods respectively. The shift-clock gate works on the sck_i edges, so those checks wait on sck_i edges and sample two time units after them, away from any edge.

// File: rtl/vcs_pkg.sv
`timescale 1ns/1ps
package vcs_pkg;
  localparam int NUM_CH  = 3;
  localparam int CH_RED  = 0;
  localparam int CH_GRN  = 1;
  localparam int CH_BLU  = 2;
endpackage

// File: rtl/vcs_regs.sv
`timescale 1ns/1ps
module vcs_regs #(
  parameter int SEL_W  = 2,
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              err_set_i,
  output logic [SEL_W-1:0]  div_sel_o,
  output logic [NUM_CH-1:0] sync_en_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int EN_LSB  = SEL_W;
  localparam int CLR_BIT = DATA_W - 1;

  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_sel_o <= '0;
      sync_en_o <= '0;
    end else if (we_i) begin
      div_sel_o <= wdata_i[SEL_W-1:0];
      sync_en_o <= wdata_i[EN_LSB +: NUM_CH];
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= 1'b0;
    else if (err_set_i)              err_q <= 1'b1;
    else if (we_i && wdata_i[CLR_BIT]) err_q <= 1'b0;
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[SEL_W-1:0]           = div_sel_o;
    rdata_o[EN_LSB +: NUM_CH]    = sync_en_o;
    rdata_o[CLR_BIT]             = err_q;
  end
endmodule

// File: rtl/vcs_clk_div.sv
`timescale 1ns/1ps
module vcs_clk_div #(
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             div_o
);
  localparam int MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1;
  localparam int CNT_W    = MAX_LOG2 - 1;

  logic [SEL_W-1:0] act_sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   half, half_m1;
  logic             term;

  always_comb begin
    half    = (CNT_W+1)'(1) << (int'(act_sel_q) + MIN_LOG2 - 1);
    half_m1 = half - (CNT_W+1)'(1);
    term    = (cnt_q == half_m1[CNT_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      div_o     <= 1'b0;
      act_sel_q <= '0;
    end else if (term) begin
      cnt_q <= '0;
      div_o <= ~div_o;
      // adopt new ratio only at end of a full period
      if (div_o) act_sel_q <= sel_i;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/vcs_sck_gate.sv
`timescale 1ns/1ps
module vcs_sck_gate (
  input  logic sck_i,
  input  logic rst_ni,
  input  logic blank_i,
  output logic sck_o
);
  logic open_q;

  // sampled while sck is low: output pulses are always whole
  always_ff @(negedge sck_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else         open_q <= ~blank_i;
  end

  assign sck_o = sck_i & open_q;
endmodule

// File: rtl/vcs_sync_route.sv
`timescale 1ns/1ps
module vcs_sync_route #(
  parameter int NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blank_i,
  input  logic              sync_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic              blank_o,
  output logic [NUM_CH-1:0] sync_o,
  output logic              err_o
);
  logic sync_ok;

  assign sync_ok = sync_i & blank_i;
  assign err_o   = sync_i & ~blank_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blank_o <= 1'b0;
    else         blank_o <= blank_i;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_o[ch] <= 1'b0;
      else         sync_o[ch] <= sync_ok & en_i[ch];
    end
  end
endmodule

// File: rtl/vid_clk_sync_ctrl.sv
`timescale 1ns/1ps
module vid_clk_sync_ctrl #(
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              blank_i,
  input  logic              sync_i,
  output logic              prg_clk_o,
  output logic              blank_o,
  output logic [2:0]        sync_rgb_o
);
  import vcs_pkg::*;

  logic [SEL_W-1:0]  div_sel;
  logic [NUM_CH-1:0] sync_en;
  logic              err_set;

  vcs_regs #(.SEL_W(SEL_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .err_set_i (err_set),
    .div_sel_o (div_sel),
    .sync_en_o (sync_en),
    .rdata_o   (reg_rdata_o)
  );

  vcs_clk_div #(.SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2)) u_div (
    .clk_i, .rst_ni,
    .sel_i (div_sel),
    .div_o (prg_clk_o)
  );

  vcs_sck_gate u_gate (
    .sck_i, .rst_ni, .blank_i,
    .sck_o
  );

  vcs_sync_route #(.NUM_CH(NUM_CH)) u_sync (
    .clk_i, .rst_ni, .blank_i, .sync_i,
    .en_i    (sync_en),
    .blank_o (blank_o),
    .sync_o  (sync_rgb_o),
    .err_o   (err_set)
  );
endmodule

// File: rtl/vcs_checker.sv
`timescale 1ns/1ps
module vcs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       blank_i,
  input logic       sync_i,
  input logic       blank_o,
  input logic [2:0] sync_rgb_o
);
  p_sync_in_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sync_rgb_o) |-> blank_o);

  p_green_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rgb_o[1] |-> $past(sync_i && blank_i && reg_rdata_o[3]));

  p_red_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rgb_o[0] |-> $past(sync_i && blank_i && reg_rdata_o[2]));

  p_blue_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rgb_o[2] |-> $past(sync_i && blank_i && reg_rdata_o[4]));

  p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !blank_i) |=> reg_rdata_o[7]);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[7] && !(reg_we_i && reg_wdata_i[7])) |=> reg_rdata_o[7]);
endmodule

bind vid_clk_sync_ctrl vcs_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .blank_i     (blank_i),
  .sync_i      (sync_i),
  .blank_o     (blank_o),
  .sync_rgb_o  (sync_rgb_o)
);

// File: tb/vid_clk_sync_ctrl_tb_top.sv
`timescale 1ns/1ps
module vid_clk_sync_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       sck = 1'b0;
  logic       rst_n;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       sck_o, blank, sync, prg_clk, blank_o;
  logic [2:0] sync_rgb;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #2 clk = ~clk;               // 250 MHz
  initial begin #1; forever #8 sck = ~sck; end

  vid_clk_sync_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sck_i(sck), .sck_o(sck_o), .blank_i(blank),
    .sync_i(sync), .prg_clk_o(prg_clk), .blank_o(blank_o), .sync_rgb_o(sync_rgb)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_div(input logic v);
    while (prg_clk !== v) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 prg_clk", prg_clk, 0);
    check("R1 sck_o", sck_o, 0);
    check("R1 blank_o", blank_o, 0);
    check("R1 sync", sync_rgb, 0);
    check("R1 rdata", rdata, 0);
  endtask

  task automatic t_div(input int sel);
    int hi, lo;
    wr(8'(sel));
    wait_div(0); wait_div(1); wait_div(0); wait_div(1);
    hi = 0; while (prg_clk) begin hi++; @(negedge clk); end
    lo = 0; while (!prg_clk) begin lo++; @(negedge clk); end
    check("R2 high phase", hi, 1 << (sel + 1));
    check("R2 low phase", lo, 1 << (sel + 1));
  endtask

  task automatic t_switch;
    int hi, lo;
    wr(8'h00);
    wait_div(0); wait_div(1); wait_div(0); wait_div(1);
    we = 1'b1; wdata = 8'h03; hi = 1;
    @(negedge clk); we = 1'b0;
    while (prg_clk) begin hi++; @(negedge clk); end
    lo = 0; while (!prg_clk) begin lo++; @(negedge clk); end
    check("R3 old high phase", hi, 2);
    check("R3 new low phase", lo, 16);
  endtask

  task automatic t_sck_pass;
    int bad = 0;
    @(negedge clk); blank = 1'b0;
    @(negedge sck); @(negedge sck);
    for (int i = 0; i < 40; i++) begin
      #1; if (sck_o !== sck) bad++;
    end
    check("R4 sck_o follows sck_i", bad, 0);
  endtask

  task automatic t_sck_blank;
    int hi = 0;
    @(posedge sck); #2 blank = 1'b1;
    #2 check("R5 pulse not cut", sck_o, 1);
    @(negedge sck);
    for (int i = 0; i < 32; i++) begin #1; if (sck_o) hi++; end
    check("R5 stopped in blank", hi, 0);
    @(posedge sck); #2 blank = 1'b0;
    #2 check("R5 no partial restart", sck_o, 0);
    @(negedge sck); @(posedge sck); #2;
    check("R5 resumes after fall", sck_o, 1);
  endtask

  task automatic t_sync(input string req, input logic [2:0] en,
                        input logic b, input logic s, input logic [2:0] exp);
    wr({3'b000, en[2], en[1], en[0], 2'b00});
    @(negedge clk); blank = b; sync = s;
    @(negedge clk);
    check(req, sync_rgb, exp);
    check("R10 blank_o", blank_o, b);
    sync = 1'b0; blank = 1'b0;
  endtask

  task automatic t_err;
    wr(8'h1C);
    @(negedge clk); blank = 1'b0; sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    check("R8 masked outside blank", sync_rgb, 0);
    check("R8 error flag set", rdata[7], 1);
    @(negedge clk);
    check("R9 error sticky", rdata[7], 1);
    wr(8'h0A);
    check("R9 plain write keeps flag", rdata, 8'h8A);
    wr(8'h9E);
    check("R9 clear and readback", rdata, 8'h1E);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; wdata = '0; blank = 1'b0; sync = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) t_div(s);
    t_switch();
    t_sck_pass();
    t_sck_blank();
    t_sync("R6 green enabled", 3'b010, 1'b1, 1'b1, 3'b010);
    t_sync("R6 green disabled", 3'b000, 1'b1, 1'b1, 3'b000);
    t_sync("R7 red only", 3'b001, 1'b1, 1'b1, 3'b001);
    t_sync("R7 blue only", 3'b100, 1'b1, 1'b1, 3'b100);
    t_sync("R7 red and blue", 3'b101, 1'b1, 1'b1, 3'b101);
    t_sync("R6 no sync input", 3'b111, 1'b1, 1'b0, 3'b000);
    t_err();
    done = 1;
    summary();
    $finish;
  end
endmodule